// File: doc/BRIEF.md
# Byte/Word Memory Lane Steering Unit

This unit sits between a 16-bit, byte-addressable memory port and a 16-bit processor datapath. On loads it takes the word returned by memory and hands the datapath either that whole word or one of its two bytes, sign-extended to 16 bits. The low address bit selects the byte. On stores it builds the word driven toward memory and produces one write strobe per byte lane, so that only the addressed bytes are written.

A byte store copies the source register's low byte into both lanes. The address bit then only has to choose which lane strobe fires, so no data shifter is needed. A word store is legal only at an even address. If a word write arrives at an odd address anyway, both strobes stay low and a sticky flag is set, which only reset clears. All outputs are registered, so every result appears one clock after its inputs are sampled.

Top module: `mem_align_unit`

## Requirements
- R1: For a byte access with `addr_lsb`=0, `load_data` is `mem_rdata[7:0]` sign-extended to 16 bits.
- R2: For a byte access with `addr_lsb`=1, `load_data` is `mem_rdata[15:8]` sign-extended to 16 bits.
- R3: For a word access (`size_word`=1), `load_data` equals `mem_rdata` unchanged.
- R4: `store_data` is `{src_data[7:0], src_data[7:0]}` when `size_word`=0, and `src_data` when `size_word`=1.
- R5: Neither lane strobe is raised when `wr_req`=0 (read).
- R6: Neither lane strobe is raised when `mem_en`=0, whatever the other controls are.
- R7: For an enabled byte write, `addr_lsb`=0 raises only `we_lo` (bits 7:0), and `addr_lsb`=1 raises only `we_hi` (bits 15:8).
- R8: An enabled word write with `addr_lsb`=0 raises both `we_hi` and `we_lo`.
- R9: An enabled word write with `addr_lsb`=1 raises no strobe and sets `misalign_flag`. The flag then stays set until reset, through any later traffic.
- R10: While `rst` is high, all outputs are cleared to zero on the clock edge, including `misalign_flag`.
- R11: Every output reflects the inputs sampled at the previous rising clock edge. Between edges, outputs do not follow input changes.

Strobe encoding in this brief is `{we_hi, we_lo}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_en | input | 1 | Memory/IO access enable for this cycle |
| wr_req | input | 1 | 1 = write, 0 = read |
| size_word | input | 1 | 1 = word access, 0 = byte access |
| addr_lsb | input | 1 | Address bit 0 |
| mem_rdata | input | 16 | Word read from memory |
| src_data | input | 16 | Source register value to be stored |
| load_data | output | 16 | Aligned, extended load result |
| store_data | output | 16 | Lane-replicated store word |
| we_hi | output | 1 | Write strobe for bits 15:8 |
| we_lo | output | 1 | Write strobe for bits 7:0 |
| misalign_flag | output | 1 | Sticky: an odd-address word write was seen |

## Verification
Two functions can act in the same cycle: strobe generation for a new legal write, and the hold of a misalignment flag already set by an earlier illegal write. The bench provokes this by following an odd-address word write directly with a legal odd-address byte write. It then checks that `we_hi` alone rises while `misalign_flag` stays high in the same sampled cycle. Only a reset pulse afterwards clears the flag.

// File: rtl/mem_align_pkg.sv
package mem_align_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 2;
  localparam int WORD_W = BYTE_W * LANES;

  typedef enum logic {
    SZ_BYTE = 1'b0,
    SZ_WORD = 1'b1
  } acc_size_e;
endpackage

// File: rtl/align_load_path.sv
module align_load_path
  import mem_align_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic [2*BW-1:0] rdata,
  input  logic            lsb,
  input  acc_size_e       size,
  output logic [2*BW-1:0] result
);
  localparam int WW = 2 * BW;

  logic [BW-1:0] picked;
  logic [WW-1:0] extended;

  always_comb begin
    picked   = lsb ? rdata[WW-1:BW] : rdata[BW-1:0];
    extended = {{BW{picked[BW-1]}}, picked};
    result   = (size == SZ_WORD) ? rdata : extended;
  end
endmodule

// File: rtl/align_store_path.sv
module align_store_path
  import mem_align_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int NL = LANES
) (
  input  logic [BW*NL-1:0] src,
  input  acc_size_e        size,
  output logic [BW*NL-1:0] wdata
);
  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign wdata[g*BW +: BW] = (size == SZ_WORD) ? src[g*BW +: BW] : src[BW-1:0];
  end
endmodule

// File: rtl/align_lane_enable.sv
module align_lane_enable
  import mem_align_pkg::*;
#(
  parameter int NL = LANES
) (
  input  logic          en,
  input  logic          wr,
  input  logic          lsb,
  input  acc_size_e     size,
  output logic [NL-1:0] lane_we,
  output logic          bad_word
);
  logic active;
  assign active   = en & wr;
  assign bad_word = active & (size == SZ_WORD) & lsb;

  for (genvar g = 0; g < NL; g++) begin : g_we
    if (g == 0) begin : g_even
      assign lane_we[g] = active & ((size == SZ_WORD) ? ~lsb : ~lsb);
    end else begin : g_odd
      assign lane_we[g] = active & ((size == SZ_WORD) ? ~lsb : lsb);
    end
  end
endmodule

// File: rtl/mem_align_unit.sv
module mem_align_unit
  import mem_align_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_en,
  input  logic              wr_req,
  input  logic              size_word,
  input  logic              addr_lsb,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [WORD_W-1:0] src_data,
  output logic [WORD_W-1:0] load_data,
  output logic [WORD_W-1:0] store_data,
  output logic              we_hi,
  output logic              we_lo,
  output logic              misalign_flag
);
  acc_size_e         size_q;
  logic [WORD_W-1:0] load_c;
  logic [WORD_W-1:0] store_c;
  logic [LANES-1:0]  we_c;
  logic              bad_c;

  assign size_q = size_word ? SZ_WORD : SZ_BYTE;

  align_load_path #(.BW(BYTE_W)) u_load (
    .rdata  (mem_rdata),
    .lsb    (addr_lsb),
    .size   (size_q),
    .result (load_c)
  );

  align_store_path #(.BW(BYTE_W), .NL(LANES)) u_store (
    .src   (src_data),
    .size  (size_q),
    .wdata (store_c)
  );

  align_lane_enable #(.NL(LANES)) u_we (
    .en       (mem_en),
    .wr       (wr_req),
    .lsb      (addr_lsb),
    .size     (size_q),
    .lane_we  (we_c),
    .bad_word (bad_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      load_data     <= '0;
      store_data    <= '0;
      we_hi         <= 1'b0;
      we_lo         <= 1'b0;
      misalign_flag <= 1'b0;
    end else begin
      load_data     <= load_c;
      store_data    <= store_c;
      we_hi         <= we_c[1];
      we_lo         <= we_c[0];
      misalign_flag <= misalign_flag | bad_c;
    end
  end
endmodule

// File: rtl/mem_align_chk.sv
module mem_align_chk (
  input logic        clk,
  input logic        rst,
  input logic        mem_en,
  input logic        wr_req,
  input logic        size_word,
  input logic        addr_lsb,
  input logic [15:0] mem_rdata,
  input logic [15:0] src_data,
  input logic [15:0] load_data,
  input logic [15:0] store_data,
  input logic        we_hi,
  input logic        we_lo,
  input logic        misalign_flag
);
  logic primed;
  always_ff @(posedge clk) primed <= !rst;

  assert_byte_lo_R1: assert property (@(posedge clk) disable iff (rst || !primed)
    $past(!size_word && !addr_lsb) |->
      load_data == {{8{$past(mem_rdata[7])}}, $past(mem_rdata[7:0])});

  assert_byte_hi_R2: assert property (@(posedge clk) disable iff (rst || !primed)
    $past(!size_word && addr_lsb) |->
      load_data == {{8{$past(mem_rdata[15])}}, $past(mem_rdata[15:8])});

  assert_word_load_R3: assert property (@(posedge clk) disable iff (rst || !primed)
    $past(size_word) |-> load_data == $past(mem_rdata));

  assert_no_we_read_R5: assert property (@(posedge clk) disable iff (rst || !primed)
    $past(!wr_req) |-> !we_hi && !we_lo);

  assert_no_we_off_R6: assert property (@(posedge clk) disable iff (rst || !primed)
    $past(!mem_en) |-> !we_hi && !we_lo);

  assert_byte_lane_R7: assert property (@(posedge clk) disable iff (rst || !primed)
    $past(mem_en && wr_req && !size_word) |->
      $onehot0({we_hi, we_lo}) && we_hi == $past(addr_lsb) && we_lo == !$past(addr_lsb));

  assert_word_both_R8: assert property (@(posedge clk) disable iff (rst || !primed)
    $past(mem_en && wr_req && size_word && !addr_lsb) |-> we_hi && we_lo);

  assert_misalign_R9: assert property (@(posedge clk) disable iff (rst || !primed)
    $past(mem_en && wr_req && size_word && addr_lsb) |->
      misalign_flag && !we_hi && !we_lo);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    misalign_flag |=> misalign_flag);
endmodule

bind mem_align_unit mem_align_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .mem_en        (mem_en),
  .wr_req        (wr_req),
  .size_word     (size_word),
  .addr_lsb      (addr_lsb),
  .mem_rdata     (mem_rdata),
  .src_data      (src_data),
  .load_data     (load_data),
  .store_data    (store_data),
  .we_hi         (we_hi),
  .we_lo         (we_lo),
  .misalign_flag (misalign_flag)
);

// File: tb/mem_align_unit_tb.sv
module mem_align_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        mem_en, wr_req, size_word, addr_lsb;
  logic [15:0] mem_rdata, src_data;
  logic [15:0] load_data, store_data;
  logic        we_hi, we_lo, misalign_flag;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  mem_align_unit u_dut (
    .clk(clk), .rst(rst), .mem_en(mem_en), .wr_req(wr_req),
    .size_word(size_word), .addr_lsb(addr_lsb), .mem_rdata(mem_rdata),
    .src_data(src_data), .load_data(load_data), .store_data(store_data),
    .we_hi(we_hi), .we_lo(we_lo), .misalign_flag(misalign_flag)
  );

  // {en, wr, word, lsb, rdata, src, exp_load, exp_store, exp_we{hi,lo}}
  localparam int NV = 10;
  localparam logic [69:0] VEC [NV] = '{
    {4'b1000, 16'h1234, 16'h00AB, 16'h0034, 16'hABAB, 2'b00}, // R1 positive
    {4'b1000, 16'h12F0, 16'h0000, 16'hFFF0, 16'h0000, 2'b00}, // R1 negative
    {4'b1001, 16'h8A55, 16'h0000, 16'hFF8A, 16'h0000, 2'b00}, // R2 negative
    {4'b1001, 16'h7F01, 16'h0000, 16'h007F, 16'h0000, 2'b00}, // R2 positive
    {4'b1010, 16'hBEEF, 16'h1357, 16'hBEEF, 16'h1357, 2'b00}, // R3 R5
    {4'b1100, 16'h0000, 16'h12C3, 16'h0000, 16'hC3C3, 2'b01}, // R7 lo R4
    {4'b1101, 16'h0000, 16'h5A66, 16'h0000, 16'h6666, 2'b10}, // R7 hi R4
    {4'b1110, 16'hFFFF, 16'hA5A5, 16'hFFFF, 16'hA5A5, 2'b11}, // R8
    {4'b0110, 16'h0080, 16'h4321, 16'h0080, 16'h4321, 2'b00}, // R6 word
    {4'b0101, 16'h80FF, 16'h0011, 16'hFF80, 16'h1111, 2'b00}  // R6 byte
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic [15:0] rd, input logic [15:0] sd);
    {mem_en, wr_req, size_word, addr_lsb} = c;
    mem_rdata = rd;
    src_data  = sd;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    drive(4'b1111, 16'hFFFF, 16'hFFFF);
    repeat (3) @(posedge clk);
    #2;
    chk("R10 reset load", load_data, 16'h0000);
    chk("R10 reset store", store_data, 16'h0000);
    chk("R10 reset strobes/flag", {13'd0, we_hi, we_lo, misalign_flag}, 16'h0000);
    @(negedge clk);
    drive(4'b0000, 16'h0000, 16'h0000);
    rst = 1'b0;
    @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][69:66], VEC[i][65:50], VEC[i][49:34]);
      @(posedge clk);
      #2;
      chk($sformatf("R1/R2/R3 load vec%0d", i), load_data, VEC[i][33:18]);
      chk($sformatf("R4 store vec%0d", i), store_data, VEC[i][17:2]);
      chk($sformatf("R5/R6/R7/R8 strobes vec%0d", i), {14'd0, we_hi, we_lo}, {14'd0, VEC[i][1:0]});
    end
    chk("R9 flag clear with legal traffic", {15'd0, misalign_flag}, 16'h0000);

    // R11: outputs hold between edges
    @(negedge clk);
    drive(4'b1000, 16'h00C0, 16'h0000);
    #3;
    chk("R11 no change before edge", load_data, 16'h0080 ^ 16'hFF00);
    @(posedge clk);
    #2;
    chk("R11 update after edge", load_data, 16'hFFC0);

    // R9: misaligned word write
    @(negedge clk);
    drive(4'b1111, 16'h0000, 16'hCAFE);
    @(posedge clk);
    #2;
    chk("R9 misaligned strobes", {14'd0, we_hi, we_lo}, 16'h0000);
    chk("R9 flag set", {15'd0, misalign_flag}, 16'h0001);

    // legal byte write in the cycle after: strobe plus held flag
    @(negedge clk);
    drive(4'b1101, 16'h0000, 16'h0042);
    @(posedge clk);
    #2;
    chk("R7 strobe with flag held", {14'd0, we_hi, we_lo}, 16'h0002);
    chk("R9 flag sticky", {15'd0, misalign_flag}, 16'h0001);
    chk("R4 store with flag held", store_data, 16'h4242);

    @(negedge clk);
    drive(4'b0000, 16'h0000, 16'h0000);
    repeat (3) @(posedge clk);
    #2;
    chk("R9 flag sticky idle", {15'd0, misalign_flag}, 16'h0001);

    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2;
    chk("R10 reset clears flag", {15'd0, misalign_flag}, 16'h0000);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    finish_run();
  end
endmodule